// File: doc/BRIEF.md
# Overlapped 15-Clock Converter Serial Sequencer

This block is the serial master for a 12-bit multichannel successive-approximation converter. It runs each conversion in a frame of only 15 serial clocks. It drives chip select, the serial clock and the command line, and it samples the converter's result line.

Frames overlap. The command for the next conversion goes out while the low bits of the previous result are still coming in. Each result therefore arrives in two parts: its upper six bits at the tail of the frame that requested it, and its lower bits at the head of the frame that follows. The block holds the upper part across the frame boundary and joins the two parts. It then presents the word together with the channel number it was converted from.

The least significant bit never shows up as a usable level on the line, so it is always returned as zero. The host holds `run` high to stream frames back to back with chip select held low. When `run` drops, one extra closing frame is sent with a host-chosen power setting, so that the last result's low bits can still be collected.

Top module: `sar15_link`

## Requirements
- R1: Every frame is exactly 15 serial-clock rising edges long. Chip select stays low across back-to-back frames and rises only after the rising edges of the closing frame. The serial clock stays low whenever chip select is high.
- R2: On rising edges 1 to 8 of a frame, `mosi` carries the command word most significant bit first: a 1, then the channel bits 2, 1 and 0, then the mode bit, then the single/differential bit, then the power bits 1 and 0. On rising edges 9 to 15, `mosi` is 0.
- R3: `mosi` changes only on a falling serial-clock edge, or when chip select falls. `miso` is sampled at the rising serial-clock edge.
- R4: Each half period of the serial clock lasts `DIV_HALF` system clocks. The time from chip select falling to the first rising edge is also `DIV_HALF` system clocks.
- R5: Result bits 11 to 6 are the `miso` samples at rising edges 10 to 15 of the frame that issued the command. Bits 5 to 1 are the samples at rising edges 1 to 5 of the next frame. Bit 0 is always 0.
- R6: `res_valid` is a single-cycle pulse. It rises in the system cycle where rising edge 5 of the following frame is produced. There is exactly one pulse per non-closing frame, and `res_chan` carries the channel of the frame that issued the command.
- R7: The channel, mode and power inputs are captured at the start of each frame. A change made in the middle of a frame takes effect from the next frame on.
- R8: When `run` is low at the end of a frame, exactly one closing frame follows. Its power bits come from `cfg_stop_pd`, and its own conversion produces no result. Chip select then goes high.
- R9: After reset, `cs_n` is 1 and `sclk`, `mosi` and `res_valid` are 0. Chip select stays high while `run` is low, and `res_valid` never pulses while chip select is high.
- R10: The first frame after chip select falls produces no result pulse, because it has no earlier conversion to complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Stream enable; dropping it requests the closing frame |
| cfg_chan | input | 3 | Channel to convert |
| cfg_mode | input | 1 | Conversion mode bit placed in the command |
| cfg_sgl | input | 1 | Single-ended (1) or differential (0) select |
| cfg_pd | input | 2 | Power bits for streaming frames |
| cfg_stop_pd | input | 2 | Power bits for the closing frame |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Command line to the converter |
| miso | input | 1 | Result line from the converter |
| res_data | output | 12 | Joined result, bit 0 forced to 0 |
| res_chan | output | 3 | Channel the result belongs to |
| res_valid | output | 1 | One-cycle strobe for `res_data` and `res_chan` |

## Verification
A wrong bit counter shows up within one frame. The command word seen by the responder moves out of place, chip select rises after some count other than 15, or the strobe appears away from rising edge 5. A stale or mis-shifted upper half shows up as a wrong result word in the very next frame. A channel tag that was not carried over shows up in the same strobe as the wrong `res_chan`. A closing frame that is missing or duplicated shows up at the end of a burst, as a result count different from the number of streaming frames.

// File: rtl/sar15_pkg.sv
package sar15_pkg;
   localparam int FRAME_CLKS = 15;
   localparam int CMD_BITS   = 8;
   localparam int RES_BITS   = 12;
   localparam int HI_BITS    = 6;
   localparam int LO_BITS    = 5;
   localparam int CHAN_W     = 3;
   localparam int PD_W       = 2;
   localparam int HI_FIRST   = FRAME_CLKS - HI_BITS + 1;
   localparam int IDX_W      = $clog2(FRAME_CLKS + 1);
   localparam int PAD_BITS   = FRAME_CLKS - CMD_BITS;

   typedef struct packed {
      logic [CHAN_W-1:0] chan;
      logic              mode;
      logic              sgl;
      logic [PD_W-1:0]   pd;
   } cmd_t;

   function automatic logic [FRAME_CLKS-1:0] frame_word(cmd_t c);
      return {1'b1, c.chan, c.mode, c.sgl, c.pd, {PAD_BITS{1'b0}}};
   endfunction
endpackage

// File: rtl/sar15_tick.sv
module sar15_tick #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (DIV_HALF < 1) begin : g_bad
         $error("sar15_tick: DIV_HALF must be at least 1");
      end
      if (DIV_HALF == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(DIV_HALF);
         localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !en)    cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
         end
         assign tick = en && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sar15_tx.sv
module sar15_tx import sar15_pkg::*; (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [FRAME_CLKS-1:0] word,
   input  logic                  shift,
   input  logic                  clear,
   output logic                  mosi
);
   logic [FRAME_CLKS-1:0] sr_q;
   always_ff @(posedge clk) begin
      if (!rst_n || clear) sr_q <= '0;
      else if (load)       sr_q <= word;
      else if (shift)      sr_q <= {sr_q[FRAME_CLKS-2:0], 1'b0};
   end
   assign mosi = sr_q[FRAME_CLKS-1];
endmodule

// File: rtl/sar15_join.sv
module sar15_join import sar15_pkg::*; (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rise,
   input  logic [IDX_W-1:0]    idx,
   input  logic                sdi,
   input  logic                frame_end,
   input  logic                trail,
   input  logic [CHAN_W-1:0]   chan_now,
   input  logic                clear,
   output logic [RES_BITS-1:0] res_data,
   output logic [CHAN_W-1:0]   res_chan,
   output logic                res_valid
);
   localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(HI_FIRST);
   localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(LO_BITS);

   logic [HI_BITS-1:0] hi_q;
   logic [LO_BITS-2:0] lo_q;
   logic [CHAN_W-1:0]  tag_q;
   logic               pend_q;
   logic               take_hi, take_lo, emit;

   assign take_hi = rise && (idx >= HI_IDX);
   assign take_lo = rise && (idx != '0) && (idx < LO_IDX);
   assign emit    = rise && (idx == LO_IDX) && pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0; lo_q <= '0; tag_q <= '0; pend_q <= 1'b0;
         res_data <= '0; res_chan <= '0; res_valid <= 1'b0;
      end else begin
         if (take_hi) hi_q <= {hi_q[HI_BITS-2:0], sdi};
         if (take_lo) lo_q <= {lo_q[LO_BITS-3:0], sdi};
         if (clear) pend_q <= 1'b0;
         else if (frame_end) begin
            pend_q <= !trail;
            tag_q  <= chan_now;
         end
         res_valid <= emit;
         if (emit) begin
            res_data <= {hi_q, lo_q, sdi, 1'b0};
            res_chan <= tag_q;
         end
      end
   end
endmodule

// File: rtl/sar15_link.sv
module sar15_link import sar15_pkg::*; #(
   parameter int DIV_HALF = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [CHAN_W-1:0]   cfg_chan,
   input  logic                cfg_mode,
   input  logic                cfg_sgl,
   input  logic [PD_W-1:0]     cfg_pd,
   input  logic [PD_W-1:0]     cfg_stop_pd,
   output logic                cs_n,
   output logic                sclk,
   output logic                mosi,
   input  logic                miso,
   output logic [RES_BITS-1:0] res_data,
   output logic [CHAN_W-1:0]   res_chan,
   output logic                res_valid
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_CLKS);

   typedef enum logic {ST_IDLE, ST_XFER} st_e;

   st_e               st_q;
   logic              sclk_q, cs_q, trail_q;
   logic [IDX_W-1:0]  idx_q;
   logic [CHAN_W-1:0] chan_q;
   logic              tick, rise, fall, last, frame_end, start;
   cmd_t              cmd_sel;

   sar15_tick #(.DIV_HALF(DIV_HALF)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(st_q == ST_XFER), .tick(tick));

   assign start     = (st_q == ST_IDLE) && run;
   assign rise      = tick && !sclk_q;
   assign fall      = tick && sclk_q;
   assign last      = (idx_q == LAST_IDX);
   assign frame_end = fall && last;

   always_comb begin
      cmd_sel.chan = cfg_chan;
      cmd_sel.mode = cfg_mode;
      cmd_sel.sgl  = cfg_sgl;
      cmd_sel.pd   = run ? cfg_pd : cfg_stop_pd;
   end

   sar15_tx u_tx (
      .clk(clk), .rst_n(rst_n),
      .load(start || (frame_end && !trail_q)),
      .word(frame_word(cmd_sel)),
      .shift(fall && !last),
      .clear(frame_end && trail_q),
      .mosi(mosi));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; sclk_q <= 1'b0; cs_q <= 1'b1;
         trail_q <= 1'b0; idx_q <= '0; chan_q <= '0;
      end else if (st_q == ST_IDLE) begin
         if (run) begin
            st_q    <= ST_XFER;
            cs_q    <= 1'b0;
            idx_q   <= IDX_W'(1);
            trail_q <= 1'b0;
            chan_q  <= cfg_chan;
         end
      end else begin
         if (rise) sclk_q <= 1'b1;
         if (fall) begin
            sclk_q <= 1'b0;
            if (!last) idx_q <= idx_q + 1'b1;
            else if (trail_q) begin
               st_q  <= ST_IDLE;
               cs_q  <= 1'b1;
               idx_q <= '0;
            end else begin
               idx_q   <= IDX_W'(1);
               trail_q <= !run;
               chan_q  <= cfg_chan;
            end
         end
      end
   end

   sar15_join u_join (
      .clk(clk), .rst_n(rst_n), .rise(rise), .idx(idx_q), .sdi(miso),
      .frame_end(frame_end), .trail(trail_q), .chan_now(chan_q),
      .clear(start), .res_data(res_data), .res_chan(res_chan),
      .res_valid(res_valid));

   assign cs_n = cs_q;
   assign sclk = sclk_q;
endmodule

// File: rtl/sar15_link_chk.sv
module sar15_link_chk import sar15_pkg::*; #(
   parameter int DIV_HALF = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n,
   input logic                sclk,
   input logic                mosi,
   input logic [RES_BITS-1:0] res_data,
   input logic                res_valid
);
   localparam int RW = $clog2(DIV_HALF + 1) + 1;
   localparam logic [RW-1:0] HALF_M1 = RW'(DIV_HALF - 1);
   localparam logic [RW-1:0] RUN_MAX = {RW{1'b1}};

   logic          sclk_d, cs_d;
   logic [4:0]    rise_cnt;
   logic [RW-1:0] run_len;
   logic          sclk_rise, changed;

   assign sclk_rise = sclk && !sclk_d;
   assign changed   = (sclk != sclk_d) || (cs_n != cs_d);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_d <= 1'b0; cs_d <= 1'b1; rise_cnt <= '0; run_len <= '0;
      end else begin
         sclk_d <= sclk;
         cs_d   <= cs_n;
         if (!cs_n && cs_d)  rise_cnt <= '0;
         else if (sclk_rise) rise_cnt <= (rise_cnt == 5'd15) ? 5'd1 : rise_cnt + 5'd1;
         if (changed)                run_len <= '0;
         else if (run_len != RUN_MAX) run_len <= run_len + 1'b1;
      end
   end

   // R1
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> rise_cnt == 5'd15);
   // R1
   idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   // R3
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));
   // R4
   half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk != sclk_d) |-> run_len == HALF_M1);
   // R5
   lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_data[0] == 1'b0);
   // R6
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   // R6
   emit_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (sclk_rise && rise_cnt == 5'd4));
   // R9
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !res_valid);
endmodule

bind sar15_link sar15_link_chk #(.DIV_HALF(DIV_HALF)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
   .res_data(res_data), .res_valid(res_valid));

// File: tb/sar15_link_test.sv
module sar15_link_test;
   localparam int DIV = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run = 1'b0;
   logic [2:0] cfg_chan = '0;
   logic cfg_mode = 1'b0, cfg_sgl = 1'b0;
   logic [1:0] cfg_pd = '0, cfg_stop_pd = '0;
   logic cs_n, sclk, mosi, miso;
   logic [11:0] res_data;
   logic [2:0] res_chan;
   logic res_valid;

   always #5 clk = ~clk;

   sar15_link #(.DIV_HALF(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .run(run), .cfg_chan(cfg_chan),
      .cfg_mode(cfg_mode), .cfg_sgl(cfg_sgl), .cfg_pd(cfg_pd),
      .cfg_stop_pd(cfg_stop_pd), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
      .miso(miso), .res_data(res_data), .res_chan(res_chan),
      .res_valid(res_valid));

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // responder model state
   int clk_no = 0, fcount = 0, frames_b = 0, res_b = 0, cs_falls = 0, first_bad = 0;
   logic [7:0] cmd = '0;
   logic [11:0] cur_s = '0, prev_s = '0;
   logic [2:0] nx_chan = '0, exp_chan = '0;
   bit nx_run = 0, exp_trail = 0;
   logic miso_r = 1'b0;
   event ev_clk3;
   logic [11:0] q_data [0:63];
   logic [2:0]  q_chan [0:63];
   int q_head = 0, q_tail = 0;

   assign miso = miso_r;

   function automatic logic [11:0] mk_sample(int f, logic [2:0] ch);
      if (f % 5 == 4) return 12'hFFF ^ {9'd0, ch};
      if (f % 5 == 2) return 12'h001;
      return 12'((f * 1237 + int'(ch) * 517 + 333) % 4096);
   endfunction

   function automatic logic dout(int k);
      if (k <= 5) return prev_s[6-k];
      if (k >= 10) return cur_s[21-k];
      return 1'b1;
   endfunction

   always @(negedge cs_n) begin
      clk_no = 0;
      cs_falls++;
      exp_chan = nx_chan;
      exp_trail = 0;
      miso_r = dout(1);
   end

   always @(posedge cs_n) begin
      if (rst_n) chk(clk_no == 15, "R1 frame length at chip-select rise", clk_no, 15);
   end

   always @(posedge sclk) begin
      clk_no = (clk_no == 15) ? 1 : clk_no + 1;
      if (clk_no <= 8) cmd = {cmd[6:0], mosi};
      else chk(mosi == 1'b0, "R2 idle command bits", int'(mosi), 0);
      if (clk_no == 3) -> ev_clk3;
      if (clk_no == 8) begin
         chk(cmd[7] == 1'b1, "R2 start bit", int'(cmd[7]), 1);
         chk(cmd[6:4] == exp_chan, "R7 channel latched at frame start", int'(cmd[6:4]), int'(exp_chan));
         chk(cmd[3] == cfg_mode && cmd[2] == cfg_sgl, "R2 mode/sgl bits",
             int'(cmd[3:2]), int'({cfg_mode, cfg_sgl}));
         chk(cmd[1:0] == (exp_trail ? cfg_stop_pd : cfg_pd), "R8 power bits",
             int'(cmd[1:0]), int'(exp_trail ? cfg_stop_pd : cfg_pd));
         cur_s = mk_sample(fcount, cmd[6:4]);
      end
      if (clk_no == 15) begin
         fcount++;
         frames_b++;
         if (!exp_trail) begin
            q_data[q_tail % 64] = cur_s & 12'hFFE;
            q_chan[q_tail % 64] = cmd[6:4];
            q_tail++;
         end
         prev_s = cur_s;
         exp_trail = !nx_run;
         exp_chan = nx_chan;
      end
   end

   always @(negedge sclk) begin
      miso_r = dout((clk_no == 15) ? 1 : clk_no + 1);
   end

   // output monitor, away from the active edge
   logic sclk_p = 1'b0, mosi_p = 1'b0, cs_p = 1'b1, val_p = 1'b0;
   int cyc = 0;
   bit first_rise = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (!cs_n && cs_p) begin cyc = 0; first_rise = 1; end
         if (sclk && !sclk_p) begin
            chk(cyc == (first_rise ? DIV : 2 * DIV), "R4 serial clock spacing",
                cyc, first_rise ? DIV : 2 * DIV);
            cyc = 0;
            first_rise = 0;
         end
         if (sclk && sclk_p && mosi != mosi_p)
            chk(0, "R3 mosi moved while sclk high", int'(mosi), int'(mosi_p));
         if (res_valid) begin
            res_b++;
            if (frames_b == 0) first_bad++;
            chk(!val_p, "R6 strobe width", 2, 1);
            chk(clk_no == 5 && sclk, "R6 strobe position", clk_no, 5);
            chk(!cs_n, "R9 strobe with chip select high", int'(cs_n), 0);
            if (q_head == q_tail) chk(0, "R6 unexpected result", 1, 0);
            else begin
               chk(res_data == q_data[q_head % 64], "R3/R5 joined result",
                   int'(res_data), int'(q_data[q_head % 64]));
               chk(res_chan == q_chan[q_head % 64], "R6 result channel",
                   int'(res_chan), int'(q_chan[q_head % 64]));
               q_head++;
            end
         end
      end
      sclk_p = sclk; mosi_p = mosi; cs_p = cs_n; val_p = res_valid;
   end

   task automatic burst(input int nfr, input logic md, input logic sg,
                        input logic [1:0] pd, input logic [1:0] spd,
                        input logic [2:0] ch0);
      @(negedge clk);
      cfg_mode = md; cfg_sgl = sg; cfg_pd = pd; cfg_stop_pd = spd;
      cfg_chan = ch0; nx_chan = ch0;
      frames_b = 0; res_b = 0; first_bad = 0;
      nx_run = 1; run = 1'b1;
      for (int f = 0; f < nfr; f++) begin
         @(ev_clk3);
         cfg_chan = cfg_chan + 3'd3;
         nx_chan = cfg_chan;
         if (f == nfr - 1) begin run = 1'b0; nx_run = 0; end
      end
      @(posedge cs_n);
      repeat (4) @(negedge clk);
      chk(frames_b == nfr + 1, "R8 one closing frame", frames_b, nfr + 1);
      chk(res_b == nfr, "R6 one result per streaming frame", res_b, nfr);
      chk(first_bad == 0, "R10 no result in first frame", first_bad, 0);
      chk(q_head == q_tail, "R8 closing frame yields no result", q_tail - q_head, 0);
      chk(cs_n && !sclk, "R1 chip select high after stop", int'({cs_n, sclk}), 2);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n == 1'b1, "R9 reset cs_n", int'(cs_n), 1);
      chk(sclk == 1'b0, "R9 reset sclk", int'(sclk), 0);
      chk(mosi == 1'b0, "R9 reset mosi", int'(mosi), 0);
      chk(res_valid == 1'b0, "R9 reset res_valid", int'(res_valid), 0);
      begin
         int f0 = cs_falls;
         repeat (40) @(negedge clk);
         chk(cs_falls == f0 && cs_n, "R9 idle while run low", cs_falls - f0, 0);
      end
      for (int c = 0; c < 16; c++)
         burst(1 + c % 6, c[3], c[2], c[1:0], ~c[1:0], c[2:0]);
      burst(20, 1'b1, 1'b0, 2'd3, 2'd0, 3'd7);
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog run did not finish actual=1 expected=0");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule